// File: doc/BRIEF.md
# Multi-Channel Packet DMA Engine

This block moves bytes between endpoint FIFOs and system memory over a set of independent channels. Software programs a channel through a small register window: it loads a start address and a byte count, then writes the channel's control word with its enable bit set. That write arms the channel. From then on the engine carries the data one byte at a time. In transmit it reads memory and hands each byte to the endpoint named in the control word. In receive it takes bytes from the endpoint and writes them to memory. The address register advances with every byte, so software takes the bytes moved as the current address minus the start address.

All armed channels share one memory master. They take turns in round-robin order, one burst per grant. The burst length comes from a two-bit field in the control word and is cut down to the bytes still owed. In mode 0 a receive ends at the end of the first packet. In mode 1 short packets are ignored and the transfer runs to its full count. A bus error response stops the channel and sets its error flag. Completion and error both raise a per-channel pending bit, which is gated by the channel's interrupt enable and cleared when software reads it.

Top module: `dma_engine`

## Requirements
- R1: Channel n's registers sit at 0x200 + 16·n: control (11 bits used) at +4, address at +8, count at +0xC. Each reads back the value written, and reads return their data one cycle after the read strobe.
- R2: Writing control with bit 0 set arms the channel. The address register then rises by one per byte moved and ends at start + bytes. Bit 0 of control reads 0 once the transfer ends.
- R3: With control bit 1 = 1 (transmit), bytes are read from memory at rising addresses and presented on the FIFO side with fifo_tx = 1 and the endpoint from control bits 7:4. With bit 1 = 0 (receive), FIFO bytes are written to memory at rising addresses.
- R4: Control bits 10:9 select the burst length: 0 → 1 beat, 1 → 4, 2 → 8, 3 → 16. Each grant moves min(burst length, bytes remaining) bytes, and mem_blen carries that number for every beat of the burst.
- R5: In mode 0 (control bit 2 = 0), a receive byte that comes with fifo_eop = 1 is the last byte of the transfer, and the transfer completes there.
- R6: In mode 1 (control bit 2 = 1), fifo_eop is ignored, and the channel runs until its full count has moved.
- R7: An error response on a memory beat sets control bit 8, clears bit 0 and stops the channel. The address stays at the faulting byte.
- R8: Offset 0x200 holds one pending bit per channel (bit n = channel n). The bit is set on completion or error only when control bit 3 is 1. A read of 0x200 clears every bit it returns, and irq is high while any bit is set.
- R9: Writing control with bit 0 = 0 stops an active channel at once: no further FIFO bytes move and no pending bit is set. Writing zero to the address register sets it to zero.
- R10: Count writes above 0x10000 are stored as 0x10000. Arming a channel whose count is 0 completes it at once, with no data movement.
- R11: When several channels are armed, grants rotate round-robin, one burst per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| irq | output | 1 | High while any pending bit is set |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write (receive), 0 = memory read |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 8 | Write byte |
| mem_blen | output | 5 | Beats in the current burst |
| mem_burst | output | 2 | Burst code from the control word |
| mem_ack | input | 1 | Beat done |
| mem_err | input | 1 | Beat error response |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| fifo_req | output | 1 | FIFO byte request |
| fifo_tx | output | 1 | 1 = byte goes toward the endpoint |
| fifo_ep | output | 4 | Endpoint number |
| fifo_wdata | output | 8 | Byte toward the endpoint |
| fifo_ack | input | 1 | FIFO byte done |
| fifo_rdata | input | 8 | Byte from the endpoint, valid with fifo_ack |
| fifo_eop | input | 1 | Byte from the endpoint ends its packet |

## Verification
Each direction is run with every burst code. Transfer lengths are chosen so the last burst is cut short, which separates correct burst sizing from sizing that overruns the remaining count. Receives with an early end of packet are run in both modes: the final address shows whether the mode decides between stopping and continuing. Two channels armed together show whether bursts alternate between them. An error mid-transfer, an abort mid-transfer, a zero count and disabled interrupts each probe one exit path. Seeded random transfers across all channels then compare the data and the final addresses.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CTRL_W = 11;
  localparam int B_EN   = 0;
  localparam int B_TX   = 1;
  localparam int B_M1   = 2;
  localparam int B_IE   = 3;
  localparam int B_EP   = 4;
  localparam int B_ERR  = 8;
  localparam int B_BST  = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_FIFO} mv_state_e;

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 17,
  parameter int MAXLEN = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [31:0]       wdata,
  input  logic              step,
  input  logic              fin_eop,
  input  logic              err,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [AW-1:0]     addr_o,
  output logic [LW-1:0]     cnt_o,
  output logic [LW-1:0]     rem_o,
  output logic              active_o,
  output logic              irq_set_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [AW-1:0]     addr_q;
  logic [LW-1:0]     cnt_q, rem_q;
  logic              en, done_c;

  assign en = ctrl_q[B_EN];

  always_comb begin
    done_c = 1'b0;
    if (en && !wr_ctrl) begin
      if (err)                                        done_c = 1'b1;
      else if (step && (rem_q == LW'(1) || fin_eop))  done_c = 1'b1;
      else if (rem_q == '0)                           done_c = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
    end else begin
      if (wr_addr)                         addr_q <= wdata[AW-1:0];
      else if (en && step && !wr_ctrl)     addr_q <= addr_q + AW'(1);
      if (wr_cnt)
        cnt_q <= (wdata > 32'(MAXLEN)) ? LW'(MAXLEN) : wdata[LW-1:0];
      if (wr_ctrl) begin
        ctrl_q <= wdata[CTRL_W-1:0];
        rem_q  <= wdata[B_EN] ? cnt_q : '0;
      end else if (en) begin
        if (step && !err) rem_q <= rem_q - LW'(1);
        if (done_c)       ctrl_q[B_EN]  <= 1'b0;
        if (err)          ctrl_q[B_ERR] <= 1'b1;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
  assign rem_o     = rem_q;
  assign active_o  = en && (rem_q != '0);
  assign irq_set_o = done_c && ctrl_q[B_IE];
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] idx,
  output logic          valid
);
  logic [IW-1:0] last_q;

  always_comb begin
    valid = 1'b0;
    idx   = last_q;
    for (int i = 1; i <= N; i++) begin
      int c;
      c = (int'(last_q) + i) % N;
      if (!valid && req[c]) begin
        valid = 1'b1;
        idx   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= IW'(N - 1);
    else if (take) last_q <= idx;
  end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 32,
  parameter int LW = 17
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         gnt_valid,
  input  logic [IW-1:0]                gnt_idx,
  input  logic [N-1:0][CTRL_W-1:0]     ctrl_v,
  input  logic [N-1:0][AW-1:0]         addr_v,
  input  logic [N-1:0][LW-1:0]         rem_v,
  output logic                         take,
  output logic                         step,
  output logic                         fin_eop,
  output logic                         err_o,
  output logic [IW-1:0]                cur,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [7:0]                   mem_wdata,
  output logic [4:0]                   mem_blen,
  output logic [1:0]                   mem_burst,
  input  logic                         mem_ack,
  input  logic                         mem_err,
  input  logic [7:0]                   mem_rdata,
  output logic                         fifo_req,
  output logic                         fifo_tx,
  output logic [3:0]                   fifo_ep,
  output logic [7:0]                   fifo_wdata,
  input  logic                         fifo_ack,
  input  logic [7:0]                   fifo_rdata,
  input  logic                         fifo_eop
);
  mv_state_e     st_q;
  logic [IW-1:0] cur_q;
  logic          tx_q, m1_q, eop_q;
  logic [3:0]    ep_q;
  logic [1:0]    bc_q;
  logic [AW-1:0] a_q;
  logic [LW-1:0] rem_q;
  logic [4:0]    left_q, blen_q;
  logic [7:0]    byte_q;
  logic          live, byte_done, last_byte;
  logic [4:0]    beats;
  logic [LW-1:0] grem;

  assign live = ctrl_v[cur_q][B_EN];

  always_comb begin
    grem  = rem_v[gnt_idx];
    beats = burst_beats(ctrl_v[gnt_idx][B_BST +: 2]);
    if (LW'(beats) > grem) beats = 5'(grem);
  end

  assign byte_done = live && ((st_q == ST_FIFO && tx_q && fifo_ack) ||
                              (st_q == ST_MEM && !tx_q && mem_ack && !mem_err));
  assign fin_eop   = byte_done && !tx_q && !m1_q && eop_q;
  assign last_byte = (rem_q == LW'(1)) || fin_eop || (left_q == 5'd1);
  assign err_o     = live && st_q == ST_MEM && mem_err;
  assign take      = (st_q == ST_IDLE) && gnt_valid;
  assign step      = byte_done;
  assign cur       = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      tx_q   <= 1'b0;
      m1_q   <= 1'b0;
      eop_q  <= 1'b0;
      ep_q   <= '0;
      bc_q   <= '0;
      a_q    <= '0;
      rem_q  <= '0;
      left_q <= '0;
      blen_q <= '0;
      byte_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (gnt_valid) begin
          cur_q  <= gnt_idx;
          tx_q   <= ctrl_v[gnt_idx][B_TX];
          m1_q   <= ctrl_v[gnt_idx][B_M1];
          ep_q   <= ctrl_v[gnt_idx][B_EP +: 4];
          bc_q   <= ctrl_v[gnt_idx][B_BST +: 2];
          a_q    <= addr_v[gnt_idx];
          rem_q  <= grem;
          left_q <= beats;
          blen_q <= beats;
          eop_q  <= 1'b0;
          st_q   <= ctrl_v[gnt_idx][B_TX] ? ST_MEM : ST_FIFO;
        end
        ST_MEM: begin
          if (!live || mem_err) st_q <= ST_IDLE;
          else if (mem_ack && tx_q) begin
            byte_q <= mem_rdata;
            st_q   <= ST_FIFO;
          end
        end
        ST_FIFO: begin
          if (!live) st_q <= ST_IDLE;
          else if (fifo_ack && !tx_q) begin
            byte_q <= fifo_rdata;
            eop_q  <= fifo_eop;
            st_q   <= ST_MEM;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (byte_done) begin
        a_q    <= a_q + AW'(1);
        rem_q  <= rem_q - LW'(1);
        left_q <= left_q - 5'd1;
        st_q   <= last_byte ? ST_IDLE : (tx_q ? ST_MEM : ST_FIFO);
      end
    end
  end

  assign mem_req    = live && st_q == ST_MEM;
  assign mem_we     = !tx_q;
  assign mem_addr   = a_q;
  assign mem_wdata  = byte_q;
  assign mem_blen   = blen_q;
  assign mem_burst  = bc_q;
  assign fifo_req   = live && st_q == ST_FIFO;
  assign fifo_tx    = tx_q;
  assign fifo_ep    = ep_q;
  assign fifo_wdata = byte_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int          NCH    = 8,
  parameter int          AW     = 32,
  parameter int          RAW    = 10,
  parameter logic [31:0] BASE   = 32'h200,
  parameter int          MAXLEN = 65536
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  output logic [4:0]     mem_blen,
  output logic [1:0]     mem_burst,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [7:0]     mem_rdata,
  output logic           fifo_req,
  output logic           fifo_tx,
  output logic [3:0]     fifo_ep,
  output logic [7:0]     fifo_wdata,
  input  logic           fifo_ack,
  input  logic [7:0]     fifo_rdata,
  input  logic           fifo_eop
);
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LW  = $clog2(MAXLEN + 1);

  logic                     in_win, is_int;
  logic [CHB-1:0]           rch;
  logic [3:0]               off;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
  logic [NCH-1:0][AW-1:0]   addr_v;
  logic [NCH-1:0][LW-1:0]   cnt_v, rem_v;
  logic [NCH-1:0]           active_v, irq_set_v;
  logic [NCH-1:0]           pend_q;
  logic [CHB-1:0]           gnt_idx, cur;
  logic                     gnt_valid, take, step, fin_eop, err;

  assign in_win = (reg_addr[RAW-1:CHB+4] == BASE[RAW-1:CHB+4]);
  assign rch    = reg_addr[CHB+3:4];
  assign off    = reg_addr[3:0];
  assign is_int = in_win && rch == '0 && off == 4'h0;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic sel;
    assign sel = in_win && reg_wr && (rch == CHB'(k));
    dma_chan #(.AW(AW), .LW(LW), .MAXLEN(MAXLEN)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (sel && off == 4'h4),
      .wr_addr  (sel && off == 4'h8),
      .wr_cnt   (sel && off == 4'hC),
      .wdata    (reg_wdata),
      .step     (step && cur == CHB'(k)),
      .fin_eop  (fin_eop),
      .err      (err && cur == CHB'(k)),
      .ctrl_o   (ctrl_v[k]),
      .addr_o   (addr_v[k]),
      .cnt_o    (cnt_v[k]),
      .rem_o    (rem_v[k]),
      .active_o (active_v[k]),
      .irq_set_o(irq_set_v[k])
    );
  end

  dma_rr_arb #(.N(NCH), .IW(CHB)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (active_v),
    .take (take),
    .idx  (gnt_idx),
    .valid(gnt_valid)
  );

  dma_mover #(.N(NCH), .IW(CHB), .AW(AW), .LW(LW)) u_mover (
    .clk       (clk),
    .rst       (rst),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .ctrl_v    (ctrl_v),
    .addr_v    (addr_v),
    .rem_v     (rem_v),
    .take      (take),
    .step      (step),
    .fin_eop   (fin_eop),
    .err_o     (err),
    .cur       (cur),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_blen  (mem_blen),
    .mem_burst (mem_burst),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .fifo_req  (fifo_req),
    .fifo_tx   (fifo_tx),
    .fifo_ep   (fifo_ep),
    .fifo_wdata(fifo_wdata),
    .fifo_ack  (fifo_ack),
    .fifo_rdata(fifo_rdata),
    .fifo_eop  (fifo_eop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      reg_rdata <= '0;
    end else begin
      pend_q <= ((reg_rd && is_int) ? '0 : pend_q) | irq_set_v;
      if (reg_rd) begin
        reg_rdata <= '0;
        if (in_win) begin
          case (off)
            4'h0: if (rch == '0) reg_rdata <= 32'(pend_q);
            4'h4: reg_rdata <= 32'(ctrl_v[rch]);
            4'h8: reg_rdata <= 32'(addr_v[rch]);
            4'hC: reg_rdata <= 32'(cnt_v[rch]);
            default: reg_rdata <= '0;
          endcase
        end
      end
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [4:0]    mem_blen,
  input logic [1:0]    mem_burst,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          fifo_req,
  input logic          fifo_tx,
  input logic [3:0]    fifo_ep,
  input logic          fifo_ack
);
  logic [4:0] cap;
  always_comb begin
    case (mem_burst)
      2'd1:    cap = 5'd4;
      2'd2:    cap = 5'd8;
      2'd3:    cap = 5'd16;
      default: cap = 5'd1;
    endcase
  end

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !mem_err |=> !mem_req || ($stable(mem_addr) && $stable(mem_we)));

  a_r3_fifo_hold: assert property (@(posedge clk) disable iff (rst)
    fifo_req && !fifo_ack |=> !fifo_req || ($stable(fifo_ep) && $stable(fifo_tx)));

  a_r3_one_side: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && fifo_req));

  a_r4_blen_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_blen != 5'd0);

  a_r4_blen_cap: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_blen <= cap);
endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_blen (mem_blen),
  .mem_burst(mem_burst),
  .mem_ack  (mem_ack),
  .mem_err  (mem_err),
  .fifo_req (fifo_req),
  .fifo_tx  (fifo_tx),
  .fifo_ep  (fifo_ep),
  .fifo_ack (fifo_ack)
);

// File: tb/dma_engine_bench.sv
module dma_engine_bench;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [9:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  logic [4:0]  mem_blen;
  logic [1:0]  mem_burst;
  logic        mem_ack = 0, mem_err = 0;
  logic        fifo_req, fifo_tx;
  logic [3:0]  fifo_ep;
  logic [7:0]  fifo_wdata, fifo_rdata = 0;
  logic        fifo_ack = 0, fifo_eop = 0;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] shadow [0:1023];
  logic [7:0] txlog [0:255];
  logic [3:0] eplog [0:255];
  logic [4:0] blog [0:255];
  int txn = 0, bn = 0;
  int rx_idx [0:15];
  int eop_at [0:15];
  logic err_en = 0;
  logic [31:0] err_addr = 0;

  dma_engine u_dma_engine (.*);

  always #10 clk = ~clk;

  function automatic int bsz(input int code);
    case (code) 1: return 4; 2: return 8; 3: return 16; default: return 1; endcase
  endfunction
  function automatic int exp_blen(input int code, input int len, input int i);
    int s, r;
    s = bsz(code);
    r = len - (i / s) * s;
    return (r < s) ? r : s;
  endfunction
  function automatic logic [7:0] rx_byte(input int ep, input int idx);
    return 8'((ep * 37 + idx * 11 + 5) & 255);
  endfunction
  function automatic logic [31:0] mk_ctrl(input int tx, input int m1, input int ie,
                                          input int ep, input int bst);
    return 32'(1 | (tx << 1) | (m1 << 2) | (ie << 3) | (ep << 4) | (bst << 9));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory and FIFO responders, driven away from the active edge
  initial begin
    logic pm, pf;
    forever begin
      @(negedge clk);
      pm = mem_ack | mem_err;
      pf = fifo_ack;
      mem_ack = 0; mem_err = 0; fifo_ack = 0; fifo_eop = 0;
      if (mem_req && !pm && ($urandom % 4 != 0)) begin
        if (err_en && mem_addr == err_addr) mem_err = 1;
        else begin
          mem_ack = 1;
          if (bn < 256) begin blog[bn] = mem_blen; bn++; end
          if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:0]];
        end
      end
      if (fifo_req && !pf && ($urandom % 3 != 0)) begin
        fifo_ack = 1;
        if (fifo_tx) begin
          if (txn < 256) begin txlog[txn] = fifo_wdata; eplog[txn] = fifo_ep; end
          txn++;
        end else begin
          fifo_rdata = rx_byte(fifo_ep, rx_idx[fifo_ep]);
          rx_idx[fifo_ep]++;
          fifo_eop = (eop_at[fifo_ep] != 0) && (rx_idx[fifo_ep] == eop_at[fifo_ep]);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = 10'(a);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask
  function automatic int ra(input int ch, input int o);
    return 32'h200 + ch * 16 + o;
  endfunction
  task automatic wait_done(input int ch);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(ra(ch, 4), d);
      if (!d[0]) return;
    end
    check("R2 channel finishes", 32'd0, 32'd1);
  endtask
  task automatic arm(input int ch, input logic [31:0] a, input int len, input logic [31:0] c);
    wr(ra(ch, 8), a);
    wr(ra(ch, 12), 32'(len));
    wr(ra(ch, 4), c);
  endtask
  task automatic clr_logs();
    txn = 0; bn = 0;
    for (int e = 0; e < 16; e++) begin rx_idx[e] = 0; eop_at[e] = 0; end
  endtask

  // single-channel transfer with full data, address and burst checks
  task automatic run_one(input int ch, input int tx, input int m1, input int ep,
                         input int bst, input int a, input int len, input int ie,
                         input string tag);
    logic [31:0] d;
    int ok;
    clr_logs();
    arm(ch, 32'(a), len, mk_ctrl(tx, m1, ie, ep, bst));
    wait_done(ch);
    rd(ra(ch, 8), d);
    check({tag, " R2 final address"}, d, 32'(a + len));
    ok = 1;
    for (int i = 0; i < len; i++) begin
      if (tx != 0) begin
        if (i >= txn || txlog[i] !== shadow[a + i] || eplog[i] !== 4'(ep)) ok = 0;
      end else begin
        if (mem[a + i] !== rx_byte(ep, i)) ok = 0;
        shadow[a + i] = mem[a + i];
      end
      if (i >= bn || blog[i] !== 5'(exp_blen(bst, len, i))) ok = 0;
    end
    check({tag, " R3 data and R4 burst sizes"}, 32'(ok), 32'd1);
    rd(32'h200, d);
    check({tag, " R8 pending"}, d, ie ? 32'(1 << ch) : 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    int ok, n0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom);
      shadow[i] = mem[i];
    end
    clr_logs();
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    rd(ra(3, 4), d);  check("R1 reset ctrl", d, 0);
    rd(ra(3, 8), d);  check("R1 reset addr", d, 0);
    rd(32'h200, d);   check("R8 reset pending", d, 0);
    check("R8 reset irq", 32'(irq), 0);

    // R1 readback and R10 clamp
    wr(ra(7, 8), 32'h0000_3F0);  rd(ra(7, 8), d);  check("R1 addr readback", d, 32'h3F0);
    wr(ra(7, 12), 32'h3_0000);   rd(ra(7, 12), d); check("R10 count clamp", d, 32'h1_0000);
    wr(ra(7, 12), 32'hFFFF);     rd(ra(7, 12), d); check("R10 count in range", d, 32'hFFFF);

    // transmit, mode 1, INCR8 with a cut-short last burst
    run_one(0, 1, 1, 3, 2, 32'h40, 20, 1, "tx8");
    rd(ra(0, 4), d);
    check("R1 R2 ctrl readback enable clear", d, mk_ctrl(1, 1, 1, 3, 2) & ~32'd1);

    // R5 receive mode 0, early end of packet
    clr_logs(); eop_at[5] = 10;
    arm(1, 32'h100, 30, mk_ctrl(0, 0, 1, 5, 1));
    wait_done(1);
    rd(ra(1, 8), d);  check("R5 mode0 stops at packet end", d, 32'h10A);
    ok = 1;
    for (int i = 0; i < 10; i++) if (mem[32'h100 + i] !== rx_byte(5, i)) ok = 0;
    if (mem[32'h10A] !== shadow[32'h10A]) ok = 0;
    check("R5 R3 receive data", 32'(ok), 1);
    for (int i = 0; i < 10; i++) shadow[32'h100 + i] = mem[32'h100 + i];
    rd(32'h200, d);   check("R5 R8 pending", d, 32'h2);

    // R6 receive mode 1, short packet ignored
    clr_logs(); eop_at[6] = 10;
    arm(2, 32'h180, 24, mk_ctrl(0, 1, 1, 6, 3));
    wait_done(2);
    rd(ra(2, 8), d);  check("R6 mode1 runs to full count", d, 32'h198);
    for (int i = 0; i < 24; i++) shadow[32'h180 + i] = mem[32'h180 + i];
    rd(32'h200, d);   check("R6 R8 one pending", d, 32'h4);

    // R7 bus error mid-transfer
    clr_logs(); err_en = 1; err_addr = 32'h205;
    arm(3, 32'h200, 16, mk_ctrl(1, 1, 1, 7, 1));
    wait_done(3);
    err_en = 0;
    rd(ra(3, 4), d);  check("R7 error bit set, enable clear", 32'(d[8:0] & 9'h101), 32'h100);
    rd(ra(3, 8), d);  check("R7 address at faulting byte", d, 32'h205);
    check("R7 bytes before fault", 32'(txn), 5);
    check("R8 irq high", 32'(irq), 1);
    rd(32'h200, d);   check("R7 R8 pending", d, 32'h8);
    rd(32'h200, d);   check("R8 clear on read", d, 0);
    check("R8 irq low after read", 32'(irq), 0);

    // R8 interrupt enable off
    run_one(0, 1, 0, 2, 0, 32'h20, 4, 0, "noie");
    check("R8 irq stays low without enable", 32'(irq), 0);

    // R11 round robin between two channels
    clr_logs();
    wr(ra(4, 8), 32'h300); wr(ra(4, 12), 16);
    wr(ra(5, 8), 32'h340); wr(ra(5, 12), 16);
    wr(ra(4, 4), mk_ctrl(1, 1, 1, 4, 1));
    wr(ra(5, 4), mk_ctrl(1, 1, 1, 9, 1));
    wait_done(4); wait_done(5);
    ok = (txn == 32);
    for (int g = 0; g < 8; g++) begin
      for (int j = 1; j < 4; j++) if (eplog[g*4 + j] !== eplog[g*4]) ok = 0;
      if (g > 0 && eplog[g*4] === eplog[g*4 - 4]) ok = 0;
    end
    check("R11 bursts alternate", 32'(ok), 1);
    rd(32'h200, d);   check("R11 R8 both pending", d, 32'h30);

    // R9 abort mid-transfer
    clr_logs();
    arm(6, 32'h380, 40, mk_ctrl(1, 1, 1, 1, 0));
    for (int i = 0; i < 2000 && txn < 6; i++) @(negedge clk);
    wr(ra(6, 4), 0); wr(ra(6, 8), 0); wr(ra(6, 12), 0);
    n0 = txn;
    repeat (60) @(negedge clk);
    check("R9 no bytes after abort", 32'(txn), 32'(n0));
    rd(ra(6, 8), d);  check("R9 address cleared", d, 0);
    rd(32'h200, d);   check("R9 no pending", d, 0);

    // R10 zero count completes at once
    clr_logs();
    arm(7, 32'h3F0, 0, mk_ctrl(1, 1, 1, 0, 0));
    repeat (5) @(negedge clk);
    rd(ra(7, 4), d);  check("R10 zero count done", 32'(d[0]), 0);
    rd(ra(7, 8), d);  check("R10 zero count address", d, 32'h3F0);
    check("R10 zero count no traffic", 32'(txn + bn), 0);
    rd(32'h200, d);   check("R10 zero count pending", d, 32'h80);

    // seeded random transfers
    for (int t = 0; t < 10; t++) begin
      int ch, tx, m1, ep, bst, a, len;
      ch = t % 8; tx = $urandom % 2; m1 = $urandom % 2; ep = $urandom % 16;
      bst = $urandom % 4; len = 1 + $urandom % 40; a = ($urandom % 24) * 40;
      run_one(ch, tx, m1, ep, bst, a, len, 1, "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule